// File: doc/BRIEF.md
# Speculative Load Consistency Guard

This block sits beside a load pipeline that lets a cache-missing load run ahead on a guessed value. It keeps a small fully associative table of such loads and of the later loads whose addresses were formed from the guessed value. It then decides, once the real data for the guessed load has come back, whether the work done on the guess may stay (commit) or must be thrown away (squash). A correct guess alone is not enough. If another thread or agent writes the cache line of any load in the group while the guess is outstanding, the ordering seen by the speculative reads may be one that no legal interleaving could give. In that case the group is squashed even though the values agree.

Each tracked load carries a tag and a group tag. The guessed load is the group head and its group tag equals its own tag. A load that depends on it carries the head's tag as its group tag. Three checking modes are selected by a two-bit input. Address mode watches remote writes to tracked lines and suits sequential-consistency and store-queue (write-to-read relaxed) orderings. Value mode ignores remote writes and instead compares a second read of each dependent load with the value it used. Weak mode, for orderings that do not keep data-dependence order, judges on the head's value alone.

Top module: `vp_load_guard`

## Requirements
- R1: The table holds ENTRIES loads (default 8). `stall_o` is high exactly when every entry is occupied, and an allocation offered while `stall_o` is high is dropped: a later return for its tag yields no verdict.
- R2: An allocation records a tag, a group tag, the line address (address bits above the low log2(LINE_BYTES) = 6 bits) and the value the load was given. A head has group tag equal to its tag, and a dependent load names its head's tag as its group tag.
- R3: A return whose tag matches a tracked head produces, on the next clock edge, `vd_valid_o`=1 with `vd_tag_o` equal to that tag. `vd_commit_o`=1 and `vd_squash_o`=0 when the returned data equals the head's value and no entry of the group is flagged. The head and all its dependents are freed at that edge.
- R4: In address mode (`mode_i` 0 or 3), a remote write or invalidation (`snp_valid_i`=1, `snp_self_i`=0) whose line address equals the line of any tracked load flags that load. A snoop to another line flags nothing. A verdict for a group with any flagged member is a squash even when the head value matches, and this covers dependent loads as well as the head.
- R5: In every mode, a head return whose data differs from the head's recorded value gives a squash verdict.
- R6: A remote snoop that hits a group member in the same cycle as that group's head return counts as arriving before the check and makes the verdict a squash (address mode).
- R7: A snoop marked as issued by the tracking thread itself (`snp_self_i`=1) flags no entry, so a later matching head return commits.
- R8: In value mode (`mode_i`=1), snoops flag nothing. A return for a dependent tag is a re-read: data unequal to that load's recorded value flags it, and the head's later verdict is a squash.
- R9: In weak mode (`mode_i`=2), neither snoops nor dependent re-reads affect the verdict. It is a commit when the head value matches and a squash otherwise.
- R10: A return whose tag matches no tracked load, or matches only a dependent load, produces no verdict.
- R11: After reset no load is tracked, `stall_o` is low and no verdict is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Check mode: 0/3 address, 1 value, 2 weak |
| alloc_valid_i | input | 1 | Allocate a tracked load this cycle |
| alloc_tag_i | input | TAG_W | Tag of the load being allocated |
| alloc_grp_i | input | TAG_W | Group tag (head's tag) |
| alloc_addr_i | input | ADDR_W | Byte address of the load |
| alloc_value_i | input | DATA_W | Value the load was given speculatively |
| stall_o | output | 1 | Table full, allocations are dropped |
| snp_valid_i | input | 1 | A snooped write or invalidation is present |
| snp_self_i | input | 1 | Snooped write came from the tracking thread |
| snp_addr_i | input | ADDR_W | Byte address of the snooped write |
| ret_valid_i | input | 1 | Load data (or re-read data) returns this cycle |
| ret_tag_i | input | TAG_W | Tag of the returning load |
| ret_data_i | input | DATA_W | Returned data |
| vd_valid_o | output | 1 | Verdict present |
| vd_tag_o | output | TAG_W | Tag of the judged head |
| vd_commit_o | output | 1 | Speculation may stay |
| vd_squash_o | output | 1 | Speculation must be discarded |

## Verification
The assertions take for granted that tags of live entries are distinct and that at most one return arrives per cycle. They also assume an allocation never coincides with a snoop to its own line or with the release of its own group. The bench keeps every tag in flight unique and issues dependent re-reads before the head's return. It also drives allocations in cycles with no snoop and no return, so the reference model and the design never disagree over an ordering the design leaves undefined.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
   typedef enum logic [1:0] {
      MODE_ADDR     = 2'd0,
      MODE_VALUE    = 2'd1,
      MODE_WEAK     = 2'd2,
      MODE_ADDR_ALT = 2'd3
   } chk_mode_e;
endpackage

// File: rtl/vpg_free_slot.sv
module vpg_free_slot #(
   parameter int ENTRIES = 8,
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0] busy_i,
   output logic               found_o,
   output logic [IDX_W-1:0]   idx_o
);
   // lowest free index wins
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!busy_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/vpg_entry_match.sv
module vpg_entry_match #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 5,
   parameter int LINE_W  = 26,
   parameter int DATA_W  = 32
) (
   input  logic [ENTRIES-1:0]             valid_i,
   input  logic [ENTRIES-1:0][TAG_W-1:0]  tag_i,
   input  logic [ENTRIES-1:0][TAG_W-1:0]  grp_i,
   input  logic [ENTRIES-1:0][LINE_W-1:0] line_i,
   input  logic [ENTRIES-1:0][DATA_W-1:0] val_i,
   input  logic [TAG_W-1:0]               ret_tag_i,
   input  logic [DATA_W-1:0]              ret_data_i,
   input  logic [LINE_W-1:0]              snp_line_i,
   output logic [ENTRIES-1:0]             tag_hit_o,
   output logic [ENTRIES-1:0]             is_head_o,
   output logic [ENTRIES-1:0]             grp_hit_o,
   output logic [ENTRIES-1:0]             line_hit_o,
   output logic [ENTRIES-1:0]             val_diff_o
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign tag_hit_o[i]  = valid_i[i] && (tag_i[i] == ret_tag_i);
      assign is_head_o[i]  = (tag_i[i] == grp_i[i]);
      assign grp_hit_o[i]  = valid_i[i] && (grp_i[i] == ret_tag_i);
      assign line_hit_o[i] = valid_i[i] && (line_i[i] == snp_line_i);
      assign val_diff_o[i] = (val_i[i] != ret_data_i);
   end
endmodule

// File: rtl/vpg_verdict.sv
module vpg_verdict #(
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire_i,
   input  logic [TAG_W-1:0] tag_i,
   input  logic             mismatch_i,
   input  logic             flagged_i,
   input  logic             weak_i,
   output logic             vd_valid_o,
   output logic [TAG_W-1:0] vd_tag_o,
   output logic             vd_commit_o,
   output logic             vd_squash_o
);
   logic             vld_q;
   logic             sq_q;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         sq_q  <= 1'b0;
         tag_q <= '0;
      end else begin
         vld_q <= fire_i;
         if (fire_i) begin
            tag_q <= tag_i;
            sq_q  <= mismatch_i | (flagged_i & ~weak_i);
         end
      end
   end

   assign vd_valid_o  = vld_q;
   assign vd_tag_o    = tag_q;
   assign vd_squash_o = vld_q & sq_q;
   assign vd_commit_o = vld_q & ~sq_q;
endmodule

// File: rtl/vp_load_guard.sv
module vp_load_guard
   import vpg_pkg::*;
#(
   parameter int ENTRIES    = 8,
   parameter int TAG_W      = 5,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              alloc_valid_i,
   input  logic [TAG_W-1:0]  alloc_tag_i,
   input  logic [TAG_W-1:0]  alloc_grp_i,
   input  logic [ADDR_W-1:0] alloc_addr_i,
   input  logic [DATA_W-1:0] alloc_value_i,
   output logic              stall_o,
   input  logic              snp_valid_i,
   input  logic              snp_self_i,
   input  logic [ADDR_W-1:0] snp_addr_i,
   input  logic              ret_valid_i,
   input  logic [TAG_W-1:0]  ret_tag_i,
   input  logic [DATA_W-1:0] ret_data_i,
   output logic              vd_valid_o,
   output logic [TAG_W-1:0]  vd_tag_o,
   output logic              vd_commit_o,
   output logic              vd_squash_o
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("vp_load_guard: ENTRIES must be at least 2");
   end
   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("vp_load_guard: LINE_BYTES must be a power of two");
   end
   if (OFF_W >= ADDR_W) begin : g_bad_addr
      $error("vp_load_guard: line offset leaves no line address");
   end
   if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("vp_load_guard: TAG_W and DATA_W must be positive");
   end

   // entry state
   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0]             viol_q;
   logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
   logic [ENTRIES-1:0][TAG_W-1:0]  grp_q;
   logic [ENTRIES-1:0][LINE_W-1:0] line_q;
   logic [ENTRIES-1:0][DATA_W-1:0] val_q;

   // mode decode
   chk_mode_e mode;
   logic      addr_watch;
   logic      value_mode;
   logic      weak_mode;
   assign mode       = chk_mode_e'(mode_i);
   assign value_mode = (mode == MODE_VALUE);
   assign weak_mode  = (mode == MODE_WEAK);
   assign addr_watch = !value_mode && !weak_mode;

   // per-entry compare
   logic [ENTRIES-1:0] tag_hit, is_head, grp_hit, line_hit, val_diff;
   logic [LINE_W-1:0]  snp_line;
   assign snp_line = LINE_W'(snp_addr_i >> OFF_W);

   vpg_entry_match #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .LINE_W(LINE_W), .DATA_W(DATA_W)
   ) i_match (
      .valid_i   (valid_q),
      .tag_i     (tag_q),
      .grp_i     (grp_q),
      .line_i    (line_q),
      .val_i     (val_q),
      .ret_tag_i (ret_tag_i),
      .ret_data_i(ret_data_i),
      .snp_line_i(snp_line),
      .tag_hit_o (tag_hit),
      .is_head_o (is_head),
      .grp_hit_o (grp_hit),
      .line_hit_o(line_hit),
      .val_diff_o(val_diff)
   );

   // free slot search
   logic             free_found;
   logic [IDX_W-1:0] free_idx;

   vpg_free_slot #(.ENTRIES(ENTRIES)) i_free (
      .busy_i (valid_q),
      .found_o(free_found),
      .idx_o  (free_idx)
   );

   // flag and verdict logic
   logic [ENTRIES-1:0] head_sel, snoop_set, reread_set, viol_now, release_v;
   logic               head_found, head_mismatch, grp_viol, do_alloc;

   assign head_sel      = tag_hit & is_head & {ENTRIES{ret_valid_i}};
   assign head_found    = |head_sel;
   assign head_mismatch = |(head_sel & val_diff);
   assign snoop_set     = line_hit & {ENTRIES{snp_valid_i & ~snp_self_i & addr_watch}};
   assign reread_set    = tag_hit & ~is_head & val_diff & {ENTRIES{ret_valid_i & value_mode}};
   assign viol_now      = viol_q | snoop_set | reread_set;
   assign grp_viol      = |(grp_hit & viol_now);
   assign release_v     = grp_hit & {ENTRIES{head_found}};
   assign do_alloc      = alloc_valid_i & free_found;
   assign stall_o       = &valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         viol_q  <= '0;
      end else begin
         valid_q <= valid_q & ~release_v;
         viol_q  <= viol_now;
         if (do_alloc) begin
            valid_q[free_idx] <= 1'b1;
            viol_q[free_idx]  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_alloc) begin
         tag_q[free_idx]  <= alloc_tag_i;
         grp_q[free_idx]  <= alloc_grp_i;
         line_q[free_idx] <= LINE_W'(alloc_addr_i >> OFF_W);
         val_q[free_idx]  <= alloc_value_i;
      end
   end

   vpg_verdict #(.TAG_W(TAG_W)) i_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (head_found),
      .tag_i      (ret_tag_i),
      .mismatch_i (head_mismatch),
      .flagged_i  (grp_viol),
      .weak_i     (weak_mode),
      .vd_valid_o (vd_valid_o),
      .vd_tag_o   (vd_tag_o),
      .vd_commit_o(vd_commit_o),
      .vd_squash_o(vd_squash_o)
   );
endmodule

// File: rtl/vpg_checker.sv
module vpg_checker #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   mode_i,
   input logic         alloc_valid_i,
   input logic         snp_valid_i,
   input logic         snp_self_i,
   input logic         ret_valid_i,
   input logic         stall_o,
   input logic [N-1:0] valid_q,
   input logic [N-1:0] viol_q,
   input logic         head_found,
   input logic         head_mismatch,
   input logic         grp_viol,
   input logic         vd_valid_o,
   input logic         vd_squash_o
);
   // R1: a full table accepts nothing
   a_r1_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o && alloc_valid_i |=> $countones(valid_q) <= $past($countones(valid_q)));

   // R3: a verdict only ever follows a return by one cycle
   a_r3_verdict_after_return: assert property (@(posedge clk) disable iff (!rst_n)
      vd_valid_o |-> $past(ret_valid_i));

   // R4: a flagged group member turns the verdict into a squash
   a_r4_flag_squashes: assert property (@(posedge clk) disable iff (!rst_n)
      head_found && grp_viol && (mode_i != 2'd2) |=> vd_valid_o && vd_squash_o);

   // R5: a value mismatch on the head is always a squash
   a_r5_mismatch_squashes: assert property (@(posedge clk) disable iff (!rst_n)
      head_found && head_mismatch |=> vd_valid_o && vd_squash_o);

   // R7: own-thread snoops leave every flag alone
   a_r7_self_store_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid_i && snp_self_i && !alloc_valid_i && (mode_i != 2'd1) |=> $stable(viol_q));

   // R9: in weak mode no flag changes except through allocation
   a_r9_weak_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd2) && !alloc_valid_i |=> $stable(viol_q));
endmodule

bind vp_load_guard vpg_checker #(.N(ENTRIES)) i_vpg_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .alloc_valid_i(alloc_valid_i),
   .snp_valid_i  (snp_valid_i),
   .snp_self_i   (snp_self_i),
   .ret_valid_i  (ret_valid_i),
   .stall_o      (stall_o),
   .valid_q      (valid_q),
   .viol_q       (viol_q),
   .head_found   (head_found),
   .head_mismatch(head_mismatch),
   .grp_viol     (grp_viol),
   .vd_valid_o   (vd_valid_o),
   .vd_squash_o  (vd_squash_o)
);

// File: tb/test_vp_load_guard.sv
module test_vp_load_guard;
   localparam int CLK_PERIOD = 10;
   localparam int N     = 8;
   localparam int TW    = 5;
   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int OFF   = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_i = 2'd0;
   logic          alloc_valid_i = 1'b0;
   logic [TW-1:0] alloc_tag_i = '0, alloc_grp_i = '0;
   logic [AW-1:0] alloc_addr_i = '0;
   logic [DW-1:0] alloc_value_i = '0;
   logic          stall_o;
   logic          snp_valid_i = 1'b0, snp_self_i = 1'b0;
   logic [AW-1:0] snp_addr_i = '0;
   logic          ret_valid_i = 1'b0;
   logic [TW-1:0] ret_tag_i = '0;
   logic [DW-1:0] ret_data_i = '0;
   logic          vd_valid_o, vd_commit_o, vd_squash_o;
   logic [TW-1:0] vd_tag_o;

   vp_load_guard #(.ENTRIES(N), .TAG_W(TW), .ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(64))
   i_vp_load_guard (.*);

   always #(CLK_PERIOD / 2) clk = ~clk;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   string cur_req  = "R11";

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   bit            m_v[N];
   bit            m_viol[N];
   int unsigned   m_tag[N], m_grp[N], m_line[N], m_val[N];
   bit            e_vld, e_sq;
   int unsigned   e_tag;

   function automatic int count_live();
      int c = 0;
      for (int i = 0; i < N; i++) c += int'(m_v[i]);
      return c;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_v[i] = 1'b0; m_viol[i] = 1'b0; end
         e_vld = 1'b0;
      end else begin
         int  live;
         int  head;
         bit  is_val, is_weak, any;
         live    = count_live();
         is_val  = (mode_i == 2'd1);
         is_weak = (mode_i == 2'd2);
         head    = -1;
         e_vld   = 1'b0;
         for (int i = 0; i < N; i++)
            if (m_v[i] && snp_valid_i && !snp_self_i && !is_val && !is_weak &&
                m_line[i] == int'(snp_addr_i >> OFF))
               m_viol[i] = 1'b1;
         if (ret_valid_i)
            for (int i = 0; i < N; i++)
               if (m_v[i] && m_tag[i] == int'(ret_tag_i)) begin
                  if (m_grp[i] == m_tag[i]) head = i;
                  else if (is_val && m_val[i] != ret_data_i) m_viol[i] = 1'b1;
               end
         if (head >= 0) begin
            any = 1'b0;
            for (int i = 0; i < N; i++)
               if (m_v[i] && m_grp[i] == int'(ret_tag_i) && m_viol[i]) any = 1'b1;
            e_vld = 1'b1;
            e_tag = ret_tag_i;
            e_sq  = (m_val[head] != ret_data_i) || (!is_weak && any);
            for (int i = 0; i < N; i++)
               if (m_v[i] && m_grp[i] == int'(ret_tag_i)) m_v[i] = 1'b0;
         end
         if (alloc_valid_i && live < N) begin
            for (int i = 0; i < N; i++)
               if (!m_v[i]) begin
                  m_v[i] = 1'b1; m_viol[i] = 1'b0;
                  m_tag[i] = alloc_tag_i; m_grp[i] = alloc_grp_i;
                  m_line[i] = int'(alloc_addr_i >> OFF); m_val[i] = alloc_value_i;
                  break;
               end
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(vd_valid_o == e_vld, cur_req, "vd_valid", vd_valid_o, e_vld);
         check(stall_o == (count_live() == N), "R1", "stall", stall_o, count_live() == N);
         if (e_vld) begin
            check(vd_tag_o == e_tag[TW-1:0], cur_req, "vd_tag", vd_tag_o, e_tag);
            check(vd_squash_o == e_sq, cur_req, "vd_squash", vd_squash_o, e_sq);
            check(vd_commit_o == !e_sq, cur_req, "vd_commit", vd_commit_o, !e_sq);
         end
      end
   end

   task automatic alloc(input int tag, input int grp, input int addr, input int val);
      alloc_valid_i = 1'b1; alloc_tag_i = TW'(tag); alloc_grp_i = TW'(grp);
      alloc_addr_i = AW'(addr); alloc_value_i = DW'(val);
      @(negedge clk);
      alloc_valid_i = 1'b0;
   endtask

   task automatic snoop(input int addr, input bit self_src);
      snp_valid_i = 1'b1; snp_addr_i = AW'(addr); snp_self_i = self_src;
      @(negedge clk);
      snp_valid_i = 1'b0; snp_self_i = 1'b0;
   endtask

   task automatic ret(input int tag, input int data);
      ret_valid_i = 1'b1; ret_tag_i = TW'(tag); ret_data_i = DW'(data);
      @(negedge clk);
      ret_valid_i = 1'b0;
   endtask

   task automatic expect_vd(input int tag, input bit sq, input string req);
      check(vd_valid_o == 1'b1, req, "verdict present", vd_valid_o, 1);
      check(vd_tag_o == TW'(tag), req, "verdict tag", vd_tag_o, tag);
      check(vd_squash_o == sq, req, "squash", vd_squash_o, sq);
      check(vd_commit_o == !sq, req, "commit", vd_commit_o, !sq);
   endtask

   task automatic expect_none(input string req);
      check(vd_valid_o == 1'b0, req, "no verdict", vd_valid_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: empty after reset
      check(stall_o == 1'b0, "R11", "stall after reset", stall_o, 0);
      expect_none("R11");

      // R3: matching head commits; R2 fields recorded
      cur_req = "R3";
      alloc(1, 1, 'h1000, 5);
      ret(1, 5);
      expect_vd(1, 1'b0, "R3");

      // R5: mismatch squashes
      cur_req = "R5";
      alloc(2, 2, 'h1100, 7);
      ret(2, 6);
      expect_vd(2, 1'b1, "R5");

      // R4: remote write same line squashes despite match; other line does not
      cur_req = "R4";
      alloc(3, 3, 'h1000, 9);
      snoop('h1038, 1'b0);
      ret(3, 9);
      expect_vd(3, 1'b1, "R4");
      alloc(4, 4, 'h1000, 9);
      snoop('h1040, 1'b0);
      ret(4, 9);
      expect_vd(4, 1'b0, "R4");

      // R4: dependent load's line also watched (R2 group linkage)
      alloc(5, 5, 'h3000, 1);
      alloc(6, 5, 'h4000, 2);
      snoop('h4010, 1'b0);
      ret(5, 1);
      expect_vd(5, 1'b1, "R4");
      ret(6, 2);
      expect_none("R2");

      // R7: own-thread store ignored
      cur_req = "R7";
      alloc(7, 7, 'h5000, 3);
      snoop('h5000, 1'b1);
      ret(7, 3);
      expect_vd(7, 1'b0, "R7");

      // R6: snoop in the same cycle as the head return
      cur_req = "R6";
      alloc(8, 8, 'h6000, 4);
      snp_valid_i = 1'b1; snp_addr_i = 'h6020; snp_self_i = 1'b0;
      ret(8, 4);
      snp_valid_i = 1'b0;
      expect_vd(8, 1'b1, "R6");

      // R8: value mode, dependent re-read differs
      cur_req = "R8";
      mode_i = 2'd1;
      alloc(9, 9, 'h7000, 10);
      alloc(12, 9, 'h7100, 20);
      ret(12, 21);
      expect_none("R10");
      ret(9, 10);
      expect_vd(9, 1'b1, "R8");
      // R8: snoops ignored in value mode, equal re-read
      alloc(13, 13, 'h7000, 10);
      alloc(14, 13, 'h7100, 20);
      snoop('h7000, 1'b0);
      ret(14, 20);
      ret(13, 10);
      expect_vd(13, 1'b0, "R8");

      // R9: weak mode ignores snoop and re-read differences
      cur_req = "R9";
      mode_i = 2'd2;
      alloc(15, 15, 'h8000, 30);
      alloc(16, 15, 'h8100, 31);
      snoop('h8000, 1'b0);
      ret(16, 99);
      ret(15, 30);
      expect_vd(15, 1'b0, "R9");
      alloc(17, 17, 'h8000, 30);
      ret(17, 29);
      expect_vd(17, 1'b1, "R9");

      // R10: unknown tag
      cur_req = "R10";
      mode_i = 2'd3;
      ret(30, 0);
      expect_none("R10");

      // R1: fill table, overflow dropped, drains
      cur_req = "R1";
      mode_i = 2'd0;
      for (int i = 0; i < N; i++) alloc(10 + i, 10 + i, 'h9000 + i * 64, i);
      check(stall_o == 1'b1, "R1", "stall when full", stall_o, 1);
      alloc(20, 20, 'hA000, 0);
      ret(20, 0);
      expect_none("R1");
      ret(10, 0);
      expect_vd(10, 1'b0, "R1");
      check(stall_o == 1'b0, "R1", "stall after free", stall_o, 0);
      for (int i = 1; i < N; i++) begin
         ret(10 + i, i);
         expect_vd(10 + i, 1'b0, "R1");
      end
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule